// File: doc/BRIEF.md
# Key-Driven Circular Bit Sequence Generator

This block builds a deterministic bit frame from a bank of small rotating registers, called sub-circles. Each sub-circle holds a short pattern of sector bits. A key, given separately for every layer, selects how many sub-circles take part (c), how many sectors each one has (n), how many rotations are run (R) and whether the sectors are read from the first one upward or from the last one downward (D). On every rotation the block reads one sector from each active sub-circle, in sub-circle order. When more than one layer is enabled, the layers take turns within each rotation.

Bits leave one per accepted cycle on a valid/ready stream. The same bit is also XORed with a message bit on a scrambler lane, so a transmit and a receive instance that hold the same key and sector contents can encode and then recover a message. Sector patterns are loaded through a plain write port while the generator is idle. A start pulse checks and latches the key. An illegal key raises an error flag and produces no output.

Top module: `circ_seq_gen`

## Requirements
- R1: After reset the block is idle: busy, outValid, frameDone and keyError are all 0.
- R2: A write with wrEn high while idle stores wrData in sub-circle wrCirc (0-based) of layer wrLayer (0-based), with bit i of wrData holding sector i+1. A write made while busy is ignored.
- R3: Within one layer, rotation k (1-based) gives one bit from each sub-circle, from sub-circle 0 up to sub-circle c-1. When D=0 the bit is taken from sector k.
- R4: When D=1, rotation k reads sector n+1-k, so the sectors are taken from the last one downward.
- R5: With layerCnt layers, rotation k emits the bits of layer 0, then those of layer 1, and so on. A layer whose R is less than k adds nothing to rotation k.
- R6: A frame holds exactly the sum over the enabled layers of R times c bits. It then ends and the block returns to idle.
- R7: On start, a key is rejected when layerCnt is 0 or above the layer maximum, or when any enabled layer has c=0, c above the sub-circle maximum, n=0, n above the sector maximum, R=0 or R>n. A rejected start sets keyError, leaves the block idle and emits nothing. An accepted start clears keyError.
- R8: start has effect only while idle. The key is latched at that start, and key inputs that change during a frame do not alter it.
- R9: A bit is transferred in each cycle where outValid and outReady are both high. While outValid is high and outReady is low, seqBit holds its value.
- R10: frameDone is high for exactly one cycle, the cycle after the last bit is transferred, and busy is already low in that cycle.
- R11: encBit equals seqBit XOR msgBit. Running the same key and sectors a second time with the encoded bits as the message gives back the original message.
- R12: A 12-bit frame made of 3 sub-circles with 4 sectors and 4 rotations is produced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Check and latch the key, then begin a frame |
| layerCnt | input | LW | Number of enabled layers |
| keyCirc | input | MAX_LAYERS*CW | Per-layer sub-circle count c, layer l at [l*CW +: CW] |
| keySect | input | MAX_LAYERS*NW | Per-layer sector count n |
| keyRot | input | MAX_LAYERS*NW | Per-layer rotation count R |
| keyDir | input | MAX_LAYERS | Per-layer direction D (1 = descending) |
| wrEn | input | 1 | Sector pattern write strobe |
| wrLayer | input | LIW | Layer index of the write |
| wrCirc | input | CIW | Sub-circle index of the write |
| wrData | input | MAX_SECT | Sector pattern, bit i = sector i+1 |
| outReady | input | 1 | Consumer accepts the current bit |
| msgBit | input | 1 | Message bit for the scrambler lane |
| outValid | output | 1 | seqBit holds a frame bit |
| seqBit | output | 1 | Current sequence bit |
| encBit | output | 1 | seqBit XOR msgBit |
| busy | output | 1 | Frame in progress |
| frameDone | output | 1 | One-cycle pulse after the last transfer |
| keyError | output | 1 | Last start was rejected |

## Verification
The hardest case to reach is a rotation in which one layer has already run out of rotations while another layer still has some left. The generator must then skip the finished layer both inside the rotation and when it moves to the next rotation. The bench reaches this case with a two-layer sweep that runs every combination of the two R values, including all four direction pairings, against an arithmetic model of the interleaving. Ready is throttled in several patterns, so that stalls happen at the edges between sub-circles, layers and rotations. A write aimed at the first sub-circle during a running frame, and a key change during a frame, are both checked on the output stream of the frame itself and of the frame that follows.

// File: rtl/csg_pkg.sv
package csg_pkg;
  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic loadKey;
    logic stepBit;
    logic wrSector;
  } csgStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } csgState_t;
endpackage

// File: rtl/csg_key_check.sv
module csg_key_check #(
  parameter int MAX_LAYERS = 2,
  parameter int MAX_CIRC   = 4,
  parameter int MAX_SECT   = 4,
  localparam int CW = $clog2(MAX_CIRC + 1),
  localparam int NW = $clog2(MAX_SECT + 1),
  localparam int LW = $clog2(MAX_LAYERS + 1)
) (
  input  logic [LW-1:0]            layerCnt,
  input  logic [MAX_LAYERS*CW-1:0] keyCirc,
  input  logic [MAX_LAYERS*NW-1:0] keySect,
  input  logic [MAX_LAYERS*NW-1:0] keyRot,
  output logic                     keyOk
);
  logic [CW-1:0] cVal;
  logic [NW-1:0] nVal;
  logic [NW-1:0] rVal;

  always_comb begin
    keyOk = (layerCnt != '0) && (int'(layerCnt) <= MAX_LAYERS);
    cVal  = '0;
    nVal  = '0;
    rVal  = '0;
    for (int l = 0; l < MAX_LAYERS; l++) begin
      if (l < int'(layerCnt)) begin
        cVal = keyCirc[l*CW +: CW];
        nVal = keySect[l*NW +: NW];
        rVal = keyRot[l*NW +: NW];
        if (cVal == '0 || int'(cVal) > MAX_CIRC) keyOk = 1'b0;
        if (nVal == '0 || int'(nVal) > MAX_SECT) keyOk = 1'b0;
        if (rVal == '0 || rVal > nVal)           keyOk = 1'b0;
      end
    end
  end
endmodule

// File: rtl/csg_ctrl.sv
module csg_ctrl
  import csg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       keyOk,
  input  logic       lastBit,
  input  logic       outReady,
  input  logic       wrEn,
  output csgStrobe_t strobe,
  output logic       outValid,
  output logic       busy,
  output logic       frameDone,
  output logic       keyError
);
  csgState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
      keyError  <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            keyError <= !keyOk;
            if (keyOk) state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (outReady && lastBit) begin
            state     <= ST_IDLE;
            frameDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadKey  = (state == ST_IDLE) && start && keyOk;
    strobe.stepBit  = (state == ST_RUN) && outReady;
    strobe.wrSector = (state == ST_IDLE) && wrEn;
    outValid        = (state == ST_RUN);
    busy            = (state == ST_RUN);
  end
endmodule

// File: rtl/csg_datapath.sv
module csg_datapath
  import csg_pkg::*;
#(
  parameter int MAX_LAYERS = 2,
  parameter int MAX_CIRC   = 4,
  parameter int MAX_SECT   = 4,
  localparam int CW  = $clog2(MAX_CIRC + 1),
  localparam int NW  = $clog2(MAX_SECT + 1),
  localparam int LW  = $clog2(MAX_LAYERS + 1),
  localparam int CIW = (MAX_CIRC > 1) ? $clog2(MAX_CIRC) : 1,
  localparam int LIW = (MAX_LAYERS > 1) ? $clog2(MAX_LAYERS) : 1,
  localparam int SIW = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  csgStrobe_t               strobe,
  input  logic [LW-1:0]            layerCnt,
  input  logic [MAX_LAYERS*CW-1:0] keyCirc,
  input  logic [MAX_LAYERS*NW-1:0] keySect,
  input  logic [MAX_LAYERS*NW-1:0] keyRot,
  input  logic [MAX_LAYERS-1:0]    keyDir,
  input  logic [LIW-1:0]           wrLayer,
  input  logic [CIW-1:0]           wrCirc,
  input  logic [MAX_SECT-1:0]      wrData,
  output logic                     outBit,
  output logic                     lastBit
);
  // Sector rings
  logic [MAX_SECT-1:0] sect [MAX_LAYERS][MAX_CIRC];

  // Latched key
  logic [CW-1:0]         kc [MAX_LAYERS];
  logic [NW-1:0]         kn [MAX_LAYERS];
  logic [NW-1:0]         kr [MAX_LAYERS];
  logic [MAX_LAYERS-1:0] kd;
  logic [LW-1:0]         kcnt;
  logic [NW-1:0]         maxR;

  // Position counters
  logic [NW-1:0]  rot;
  logic [LIW-1:0] layIdx;
  logic [CIW-1:0] cirIdx;

  logic [NW-1:0]  rawMaxR;
  logic           hasNext;
  logic [LIW-1:0] nextLay;
  logic [LIW-1:0] firstNext;
  logic           cirLast;
  logic [NW-1:0]  sIdxWide;
  logic [SIW-1:0] sIdx;

  // Longest rotation count among the enabled layers of the incoming key
  always_comb begin
    rawMaxR = '0;
    for (int l = 0; l < MAX_LAYERS; l++) begin
      if (l < int'(layerCnt) && keyRot[l*NW +: NW] > rawMaxR)
        rawMaxR = keyRot[l*NW +: NW];
    end
  end

  // Next layer in this rotation, and first layer of the next rotation
  always_comb begin
    hasNext   = 1'b0;
    nextLay   = '0;
    firstNext = '0;
    for (int l = MAX_LAYERS - 1; l >= 0; l--) begin
      if (l > int'(layIdx) && l < int'(kcnt) && rot <= kr[l]) begin
        hasNext = 1'b1;
        nextLay = LIW'(l);
      end
      if (l < int'(kcnt) && ({1'b0, rot} + (NW+1)'(1)) <= {1'b0, kr[l]})
        firstNext = LIW'(l);
    end
  end

  assign cirLast = ((CW'(cirIdx) + CW'(1)) == kc[layIdx]);
  assign lastBit = cirLast && !hasNext && (rot == maxR);

  // Sector selection: ascending or descending with the rotation number
  assign sIdxWide = kd[layIdx] ? (kn[layIdx] - rot) : (rot - NW'(1));
  assign sIdx     = SIW'(sIdxWide);
  assign outBit   = sect[layIdx][cirIdx][sIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < MAX_LAYERS; l++) begin
        kc[l] <= '0;
        kn[l] <= '0;
        kr[l] <= '0;
        for (int c = 0; c < MAX_CIRC; c++) sect[l][c] <= '0;
      end
      kd     <= '0;
      kcnt   <= '0;
      maxR   <= '0;
      rot    <= '0;
      layIdx <= '0;
      cirIdx <= '0;
    end else begin
      if (strobe.wrSector && int'(wrLayer) < MAX_LAYERS && int'(wrCirc) < MAX_CIRC)
        sect[wrLayer][wrCirc] <= wrData;

      if (strobe.loadKey) begin
        for (int l = 0; l < MAX_LAYERS; l++) begin
          kc[l] <= keyCirc[l*CW +: CW];
          kn[l] <= keySect[l*NW +: NW];
          kr[l] <= keyRot[l*NW +: NW];
        end
        kd     <= keyDir;
        kcnt   <= layerCnt;
        maxR   <= rawMaxR;
        rot    <= NW'(1);
        layIdx <= '0;
        cirIdx <= '0;
      end else if (strobe.stepBit) begin
        if (!cirLast) begin
          cirIdx <= cirIdx + CIW'(1);
        end else begin
          cirIdx <= '0;
          if (hasNext) begin
            layIdx <= nextLay;
          end else begin
            rot    <= rot + NW'(1);
            layIdx <= firstNext;
          end
        end
      end
    end
  end
endmodule

// File: rtl/circ_seq_gen.sv
module circ_seq_gen
  import csg_pkg::*;
#(
  parameter int MAX_LAYERS = 2,
  parameter int MAX_CIRC   = 4,
  parameter int MAX_SECT   = 4,
  localparam int CW  = $clog2(MAX_CIRC + 1),
  localparam int NW  = $clog2(MAX_SECT + 1),
  localparam int LW  = $clog2(MAX_LAYERS + 1),
  localparam int CIW = (MAX_CIRC > 1) ? $clog2(MAX_CIRC) : 1,
  localparam int LIW = (MAX_LAYERS > 1) ? $clog2(MAX_LAYERS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [LW-1:0]            layerCnt,
  input  logic [MAX_LAYERS*CW-1:0] keyCirc,
  input  logic [MAX_LAYERS*NW-1:0] keySect,
  input  logic [MAX_LAYERS*NW-1:0] keyRot,
  input  logic [MAX_LAYERS-1:0]    keyDir,
  input  logic                     wrEn,
  input  logic [LIW-1:0]           wrLayer,
  input  logic [CIW-1:0]           wrCirc,
  input  logic [MAX_SECT-1:0]      wrData,
  input  logic                     outReady,
  input  logic                     msgBit,
  output logic                     outValid,
  output logic                     seqBit,
  output logic                     encBit,
  output logic                     busy,
  output logic                     frameDone,
  output logic                     keyError
);
  csgStrobe_t strobe;
  logic       keyOk;
  logic       lastBit;
  logic       dpBit;

  csg_key_check #(
    .MAX_LAYERS(MAX_LAYERS), .MAX_CIRC(MAX_CIRC), .MAX_SECT(MAX_SECT)
  ) keychk_i (
    .layerCnt(layerCnt), .keyCirc(keyCirc), .keySect(keySect),
    .keyRot(keyRot), .keyOk(keyOk)
  );

  csg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .keyOk(keyOk),
    .lastBit(lastBit), .outReady(outReady), .wrEn(wrEn),
    .strobe(strobe), .outValid(outValid), .busy(busy),
    .frameDone(frameDone), .keyError(keyError)
  );

  csg_datapath #(
    .MAX_LAYERS(MAX_LAYERS), .MAX_CIRC(MAX_CIRC), .MAX_SECT(MAX_SECT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .layerCnt(layerCnt),
    .keyCirc(keyCirc), .keySect(keySect), .keyRot(keyRot), .keyDir(keyDir),
    .wrLayer(wrLayer), .wrCirc(wrCirc), .wrData(wrData),
    .outBit(dpBit), .lastBit(lastBit)
  );

  // Scrambler lane
  assign seqBit = outValid & dpBit;
  assign encBit = seqBit ^ msgBit;
endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int MAX_LAYERS = 2,
  parameter int MAX_CIRC   = 4,
  parameter int MAX_SECT   = 4,
  localparam int CW = $clog2(MAX_CIRC + 1),
  localparam int NW = $clog2(MAX_SECT + 1),
  localparam int LW = $clog2(MAX_LAYERS + 1)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     start,
  input logic [LW-1:0]            layerCnt,
  input logic [MAX_LAYERS*CW-1:0] keyCirc,
  input logic [MAX_LAYERS*NW-1:0] keyRot,
  input logic                     outReady,
  input logic                     outValid,
  input logic                     seqBit,
  input logic                     busy,
  input logic                     frameDone,
  input logic                     keyError,
  input logic                     keyOk
);
  int expLen;
  int sentCnt;
  int keyLen;

  always_comb begin
    keyLen = 0;
    for (int l = 0; l < MAX_LAYERS; l++)
      if (l < int'(layerCnt))
        keyLen += int'(keyRot[l*NW +: NW]) * int'(keyCirc[l*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expLen  <= 0;
      sentCnt <= 0;
    end else if (start && !busy && keyOk) begin
      expLen  <= keyLen;
      sentCnt <= 0;
    end else if (outValid && outReady) begin
      sentCnt <= sentCnt + 1;
    end
  end

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (sentCnt == expLen));

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (sentCnt < expLen));

  // R7
  key_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !keyOk) |=> (keyError && !busy && !outValid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(seqBit)));

  // R10
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!busy && $past(outValid && outReady)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
endmodule

bind circ_seq_gen csg_checker #(
  .MAX_LAYERS(MAX_LAYERS), .MAX_CIRC(MAX_CIRC), .MAX_SECT(MAX_SECT)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .layerCnt(layerCnt),
  .keyCirc(keyCirc), .keyRot(keyRot), .outReady(outReady),
  .outValid(outValid), .seqBit(seqBit), .busy(busy),
  .frameDone(frameDone), .keyError(keyError), .keyOk(keyOk)
);

// File: tb/circ_seq_gen_tb_top.sv
module circ_seq_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int CW = 3;
  localparam int NW = 3;
  localparam int LW = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [LW-1:0]   layerCnt = '0;
  logic [NL*CW-1:0] keyCirc = '0;
  logic [NL*NW-1:0] keySect = '0;
  logic [NL*NW-1:0] keyRot = '0;
  logic [NL-1:0]   keyDir = '0;
  logic            wrEn = 1'b0;
  logic [0:0]      wrLayer = '0;
  logic [1:0]      wrCirc = '0;
  logic [NS-1:0]   wrData = '0;
  logic            outReady = 1'b0;
  logic            msgBit = 1'b0;
  logic            outValid, seqBit, encBit, busy, frameDone, keyError;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0] tbSec [NL][NC];
  int tbC [NL];
  int tbN [NL];
  int tbR [NL];
  int tbD [NL];
  int tbCnt;

  logic [63:0] expVec, gotVec, encVec, msgVec;
  int expLen, gotLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_seq_gen #(.MAX_LAYERS(NL), .MAX_CIRC(NC), .MAX_SECT(NS)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .layerCnt(layerCnt),
    .keyCirc(keyCirc), .keySect(keySect), .keyRot(keyRot), .keyDir(keyDir),
    .wrEn(wrEn), .wrLayer(wrLayer), .wrCirc(wrCirc), .wrData(wrData),
    .outReady(outReady), .msgBit(msgBit), .outValid(outValid),
    .seqBit(seqBit), .encBit(encBit), .busy(busy),
    .frameDone(frameDone), .keyError(keyError)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrSec(input int l, input int c, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrLayer = l[0:0]; wrCirc = c[1:0]; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    tbSec[l][c] = d;
  endtask

  task automatic setKey(input int l, input int c, input int n, input int r, input int d);
    tbC[l] = c; tbN[l] = n; tbR[l] = r; tbD[l] = d;
    keyCirc[l*CW +: CW] = CW'(c);
    keySect[l*NW +: NW] = NW'(n);
    keyRot[l*NW +: NW]  = NW'(r);
    keyDir[l]           = d[0];
  endtask

  task automatic setCnt(input int n);
    tbCnt = n; layerCnt = LW'(n);
  endtask

  task automatic startFrame();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Model: rotation-major, then layer, then sub-circle
  task automatic buildExp();
    int maxR, idx;
    expVec = '0; expLen = 0; maxR = 0;
    for (int l = 0; l < tbCnt; l++) if (tbR[l] > maxR) maxR = tbR[l];
    for (int k = 1; k <= maxR; k++)
      for (int l = 0; l < tbCnt; l++)
        if (k <= tbR[l])
          for (int c = 0; c < tbC[l]; c++) begin
            idx = (tbD[l] != 0) ? (tbN[l] - k) : (k - 1);
            expVec[expLen] = tbSec[l][c][idx];
            expLen++;
          end
  endtask

  function automatic bit rdy(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 1;
      2: return (cyc % 2) == 0;
      default: return (cyc % 5) < 2;
    endcase
  endfunction

  // Called right after startFrame; collects the stream and checks it
  task automatic runFrame(input string tag, input int mode,
                          input bit midKey, input bit midWrite);
    bit accPrev, doneSeen, doneOk, stallPend, stallBad, stallBit;
    accPrev = 0; doneSeen = 0; doneOk = 0; stallPend = 0; stallBad = 0; stallBit = 0;
    gotVec = '0; encVec = '0; gotLen = 0;
    buildExp();
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (frameDone) begin
        doneSeen = 1;
        doneOk = accPrev && !busy && !outValid && (gotLen == expLen);
        break;
      end
      outReady = rdy(mode, cyc);
      msgBit = msgVec[gotLen];
      if (midWrite && gotLen == 1) begin
        wrEn = 1'b1; wrLayer = 1'b0; wrCirc = 2'd0; wrData = ~tbSec[0][0];
      end
      #1;
      if (stallPend && outValid && seqBit !== stallBit) stallBad = 1;
      stallPend = outValid && !outReady;
      stallBit = seqBit;
      accPrev = outValid && outReady;
      if (accPrev) begin
        gotVec[gotLen] = seqBit;
        encVec[gotLen] = encBit;
        gotLen++;
      end
      if (midKey && gotLen == 1) begin
        keyCirc = '1; keySect = '0; keyRot = '1; keyDir = ~keyDir; layerCnt = '1;
      end
      @(posedge clk);
      @(negedge clk);
      wrEn = 1'b0;
    end
    outReady = 1'b0;
    msgBit = 1'b0;
    chk(gotVec == expVec && gotLen == expLen, tag, "stream", gotVec, expVec);
    chk(doneSeen && doneOk, "R10", "done pulse after last bit", {63'd0, doneOk}, 64'd1);
    if (mode != 0) chk(!stallBad, "R9", "bit held during stall", {63'd0, stallBad}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    msgVec = '0;
    for (int l = 0; l < NL; l++) for (int c = 0; c < NC; c++) tbSec[l][c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !outValid && !frameDone && !keyError, "R1", "reset idle",
        {60'd0, busy, outValid, frameDone, keyError}, 64'd0);

    // R2 R3 worked example: {1,0,1} {1,1,0} {1,0,0} {0,0,1}, D=0, R=2
    wrSec(0, 0, 4'b0101); wrSec(0, 1, 4'b0011);
    wrSec(0, 2, 4'b0001); wrSec(0, 3, 4'b0100);
    setCnt(1); setKey(0, 4, 3, 2, 0);
    startFrame();
    runFrame("R3", 0, 0, 0);
    chk(gotVec[7:0] == 8'h27 && gotLen == 8, "R2", "worked example 11100100",
        {56'd0, gotVec[7:0]}, 64'h27);

    // R4 descending on the same pattern: sectors 3,2,1
    setKey(0, 4, 3, 3, 1);
    startFrame();
    runFrame("R4", 1, 0, 0);

    // R12 twelve-bit frame: 3 sub-circles x 4 sectors x 4 rotations
    wrSec(0, 0, 4'b1001); wrSec(0, 1, 4'b1011); wrSec(0, 2, 4'b0110);
    setKey(0, 3, 4, 4, 0);
    startFrame();
    runFrame("R12", 0, 0, 0);
    chk(gotLen == 12, "R12", "length 12", 64'(gotLen), 64'd12);

    // Fill all rings with distinct patterns
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++) wrSec(l, c, 4'((l * 7 + c * 5 + 3) % 16));

    // R3 R4 R6 single-layer sweep over every legal key
    for (int c = 1; c <= NC; c++)
      for (int n = 1; n <= NS; n++)
        for (int r = 1; r <= n; r++)
          for (int d = 0; d < 2; d++) begin
            setCnt(1); setKey(0, c, n, r, d);
            startFrame();
            runFrame(d ? "R4" : "R6", (c + n + r + d) % 4, 0, 0);
          end

    // R5 two-layer sweep with unequal rotation counts
    for (int r0 = 1; r0 <= 4; r0++)
      for (int c1 = 1; c1 <= NC; c1++)
        for (int r1 = 1; r1 <= 4; r1++)
          for (int d = 0; d < 4; d++) begin
            setCnt(2); setKey(0, 3, 4, r0, d & 1); setKey(1, c1, 4, r1, d >> 1);
            startFrame();
            runFrame("R5", (r0 + r1 + d) % 4, 0, 0);
          end

    // R7 rejected keys
    for (int t = 0; t < 5; t++) begin
      setCnt(1); setKey(0, 2, 3, 2, 0);
      case (t)
        0: setKey(0, 2, 3, 4, 0);
        1: setKey(0, 0, 3, 2, 0);
        2: setKey(0, 2, 0, 0, 0);
        3: setCnt(0);
        default: begin setCnt(2); setKey(1, 2, 2, 0, 0); end
      endcase
      startFrame();
      chk(keyError && !busy && !outValid, "R7", "key rejected",
          {61'd0, keyError, busy, outValid}, 64'h4);
      outReady = 1'b1;
      repeat (3) @(negedge clk);
      chk(!outValid && !frameDone, "R7", "no output for rejected key",
          {62'd0, outValid, frameDone}, 64'd0);
      outReady = 1'b0;
    end
    setCnt(1); setKey(0, 2, 3, 2, 1);
    startFrame();
    chk(!keyError, "R7", "accepted start clears error", {63'd0, keyError}, 64'd0);
    runFrame("R7", 0, 0, 0);

    // R8 key inputs change mid-frame
    setCnt(2); setKey(0, 3, 4, 4, 1); setKey(1, 2, 3, 3, 0);
    startFrame();
    runFrame("R8", 2, 1, 0);
    setCnt(2); setKey(0, 3, 4, 4, 1); setKey(1, 2, 3, 3, 0);

    // R2 write while busy is ignored, in this frame and the next
    startFrame();
    runFrame("R2", 1, 0, 1);
    startFrame();
    runFrame("R2", 0, 0, 0);

    // R8 start while busy is ignored: frame is unchanged
    setCnt(1); setKey(0, 4, 4, 4, 0);
    startFrame();
    start = 1'b1;
    setKey(0, 1, 1, 1, 0);
    @(negedge clk);
    start = 1'b0;
    setKey(0, 4, 4, 4, 0);
    runFrame("R8", 0, 0, 0);

    // R11 scramble then descramble
    setCnt(2); setKey(0, 3, 4, 4, 0); setKey(1, 4, 4, 2, 1);
    for (int i = 0; i < 64; i++) msgVec[i] = ((i * 7 + 3) % 5) < 2;
    startFrame();
    runFrame("R11", 3, 0, 0);
    begin
      logic [63:0] mask, origMsg, enc1;
      mask = (64'd1 << expLen) - 64'd1;
      origMsg = msgVec;
      enc1 = encVec;
      chk((enc1 & mask) == ((expVec ^ origMsg) & mask), "R11", "encoded bits",
          enc1 & mask, (expVec ^ origMsg) & mask);
      msgVec = enc1;
      startFrame();
      runFrame("R11", 1, 0, 0);
      chk((encVec & mask) == (origMsg & mask), "R11", "round trip recovers message",
          encVec & mask, origMsg & mask);
      msgVec = '0;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule